// File: doc/BRIEF.md
# Threshold-Qualified Event Counter

This block counts hardware events for performance monitoring. Every clock it receives a small multi-bit event count, which says how many events happened in that cycle. A 32-bit control word decides how that input advances a 48-bit counter. It can compare the input against an 8-bit threshold, in either sense. It can count only the rising transitions of the qualified condition. Or, with a zero threshold, it can add the raw count directly.

Counting runs only while the control word's local enable bit and an external global enable input are both high. When the counter carries out of its top bit, a sticky overflow flag is set. If interrupts are enabled in the control word, that flag drives one request line per core, and each line is gated by its own bit of a per-core enable mask.

Software writes and reads the control word and the counter through simple write strobes and read-data outputs. A separate pulse clears the overflow flag.

Top module: `evt_thresh_counter`

## Requirements
- R1: After reset the control word, the counter, the overflow flag and every core request output read zero.
- R2: A control write strobe loads the full 32-bit word, which reads back unchanged from the next cycle. A counter write strobe loads all 48 bits, which read back unchanged from the next cycle.
- R3: The counter changes only in cycles where control bit 22 (local enable) and the global enable input are both 1. A counter write is the one exception.
- R4: With the threshold field (control bits 31:24) nonzero and control bit 23 clear, the counter advances by exactly one in each enabled cycle where the event count is greater than or equal to the threshold. In all other enabled cycles it holds.
- R5: With the threshold nonzero and control bit 23 set, the counter advances by exactly one in each enabled cycle where the event count is below the threshold. In all other enabled cycles it holds.
- R6: With the threshold zero and edge mode off, the counter adds the full event count in every enabled cycle, whatever the value of bit 23.
- R7: With control bit 18 set, the counter advances by one only in an enabled cycle where the qualified condition is 1 and was 0 in the previous clock. With a zero threshold, the qualified condition is "event count nonzero". The previous-condition register is updated every clock and resets to 0.
- R8: The counter wraps modulo 2^48. A carry out of bit 47 sets the sticky overflow flag. The clear pulse resets the flag, but a carry in the same cycle wins.
- R9: Core request output i is 1 exactly when the overflow flag is 1, control bit 20 is 1 and core enable bit i is 1.
- R10: A counter write in the same cycle as an increment wins. The written value is loaded, and that cycle cannot set the overflow flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_count | input | 8 | Events seen this cycle |
| glb_en | input | 1 | External global count enable |
| core_irq_en | input | 4 | Per-core request enable mask |
| ctl_wr | input | 1 | Control word write strobe |
| ctl_wdata | input | 32 | Control word write data |
| ctl_rdata | output | 32 | Current control word |
| cnt_wr | input | 1 | Counter write strobe |
| cnt_wdata | input | 48 | Counter write data |
| cnt_rdata | output | 48 | Current counter value |
| ovf_clr | input | 1 | Clears the sticky overflow flag |
| ovf_flag | output | 1 | Sticky overflow status |
| core_irq | output | 4 | Per-core overflow interrupt requests |

## Verification
Overflow is the hard case to reach: counting up to 2^48 from reset is out of reach. The stimulus therefore preloads the counter a few counts below the top and then lets thresholded, raw and edge-mode increments carry it over. It also places a counter write and an overflowing increment in the same cycle, and a clear pulse on the same cycle as a new carry. A behavioural model compares every output on every clock through all of these sequences.

// File: rtl/evtc_pkg.sv
package evtc_pkg;
  localparam int CTL_W    = 32;
  localparam int EDGE_BIT = 18;
  localparam int IRQ_BIT  = 20;
  localparam int LEN_BIT  = 22;
  localparam int INV_BIT  = 23;
  localparam int THR_LSB  = 24;
  localparam int THR_W    = 8;

  typedef struct packed {
    logic             edge_mode;
    logic             irq_on;
    logic             local_en;
    logic             invert;
    logic [THR_W-1:0] thresh;
  } ctl_fields_t;

  function automatic ctl_fields_t decode_ctl(input logic [CTL_W-1:0] w);
    ctl_fields_t f;
    f.edge_mode = w[EDGE_BIT];
    f.irq_on    = w[IRQ_BIT];
    f.local_en  = w[LEN_BIT];
    f.invert    = w[INV_BIT];
    f.thresh    = w[THR_LSB +: THR_W];
    return f;
  endfunction
endpackage

// File: rtl/evtc_qualifier.sv
module evtc_qualifier
  import evtc_pkg::*;
#(
  parameter int EVT_W = 8,
  parameter int CNT_W = 48
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [EVT_W-1:0]     evt_count,
  input  ctl_fields_t          fields,
  input  logic                 glb_en,
  output logic                 active,
  output logic [CNT_W-1:0]     inc
);
  localparam int CMP_W = (EVT_W > THR_W) ? EVT_W : THR_W;

  logic [CMP_W-1:0] evt_ext;
  logic [CMP_W-1:0] thr_ext;
  logic             thr_zero;
  logic             cond;
  logic             prev_cond_q;
  logic             prev_cond_d;

  always_comb begin
    evt_ext  = CMP_W'(evt_count);
    thr_ext  = CMP_W'(fields.thresh);
    thr_zero = (fields.thresh == '0);
    active   = fields.local_en & glb_en;
    if (thr_zero)          cond = (evt_count != '0);
    else if (fields.invert) cond = (evt_ext < thr_ext);
    else                   cond = (evt_ext >= thr_ext);
    prev_cond_d = cond;
  end

  always_comb begin
    inc = '0;
    if (active) begin
      if (fields.edge_mode)  inc = CNT_W'(cond & ~prev_cond_q);
      else if (thr_zero)     inc = CNT_W'(evt_count);
      else                   inc = CNT_W'(cond);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_cond_q <= 1'b0;
    else        prev_cond_q <= prev_cond_d;
  end

  // R7: edge mode never steps by more than one
  a_r7_edge_single: assert property (@(posedge clk) disable iff (!rst_n)
    fields.edge_mode |-> (inc <= CNT_W'(1)));
  // R3: nothing is added while disabled
  a_r3_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> (inc == '0));
endmodule

// File: rtl/evtc_accum.sv
module evtc_accum #(
  parameter int CNT_W = 48
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] inc,
  input  logic             cnt_wr,
  input  logic [CNT_W-1:0] cnt_wdata,
  input  logic             ovf_clr,
  output logic [CNT_W-1:0] cnt_q,
  output logic             ovf_q
);
  logic [CNT_W:0]   sum;
  logic [CNT_W-1:0] cnt_d;
  logic             ovf_d;
  logic             carry_set;

  always_comb begin
    sum       = {1'b0, cnt_q} + {1'b0, inc};
    carry_set = sum[CNT_W] & ~cnt_wr;
    cnt_d     = cnt_wr ? cnt_wdata : sum[CNT_W-1:0];
    ovf_d     = carry_set | (ovf_q & ~ovf_clr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      ovf_q <= ovf_d;
    end
  end

  // R10 / R2: a write lands unchanged
  a_r10_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_wr |=> (cnt_q == $past(cnt_wdata)));
  // R8: the flag stays set until cleared
  a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_q && !ovf_clr) |=> ovf_q);
  // R3: no increment and no write keeps the counter still
  a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (inc == '0 && !cnt_wr) |=> $stable(cnt_q));
endmodule

// File: rtl/evtc_irq_router.sv
module evtc_irq_router #(
  parameter int NUM_CORES = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ovf,
  input  logic                 irq_on,
  input  logic [NUM_CORES-1:0] core_en,
  output logic [NUM_CORES-1:0] core_irq
);
  logic pending;
  assign pending = ovf & irq_on;

  for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
    assign core_irq[c] = pending & core_en[c];
  end

  // R9: no request on a masked core
  a_r9_masked: assert property (@(posedge clk) disable iff (!rst_n)
    (core_irq & ~core_en) == '0);
  // R9: requests only come from a set flag
  a_r9_needs_ovf: assert property (@(posedge clk) disable iff (!rst_n)
    !ovf |-> (core_irq == '0));
endmodule

// File: rtl/evt_thresh_counter.sv
module evt_thresh_counter
  import evtc_pkg::*;
#(
  parameter int EVT_W     = 8,
  parameter int CNT_W     = 48,
  parameter int NUM_CORES = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [EVT_W-1:0]     evt_count,
  input  logic                 glb_en,
  input  logic [NUM_CORES-1:0] core_irq_en,
  input  logic                 ctl_wr,
  input  logic [CTL_W-1:0]     ctl_wdata,
  output logic [CTL_W-1:0]     ctl_rdata,
  input  logic                 cnt_wr,
  input  logic [CNT_W-1:0]     cnt_wdata,
  output logic [CNT_W-1:0]     cnt_rdata,
  input  logic                 ovf_clr,
  output logic                 ovf_flag,
  output logic [NUM_CORES-1:0] core_irq
);
  logic [CTL_W-1:0] ctl_q;
  logic [CTL_W-1:0] ctl_d;
  ctl_fields_t      fields;
  logic             active;
  logic [CNT_W-1:0] inc;

  always_comb begin
    ctl_d  = ctl_wr ? ctl_wdata : ctl_q;
    fields = decode_ctl(ctl_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctl_q <= '0;
    else        ctl_q <= ctl_d;
  end

  evtc_qualifier #(.EVT_W(EVT_W), .CNT_W(CNT_W)) u_qual (
    .clk(clk), .rst_n(rst_n), .evt_count(evt_count), .fields(fields),
    .glb_en(glb_en), .active(active), .inc(inc)
  );

  evtc_accum #(.CNT_W(CNT_W)) u_acc (
    .clk(clk), .rst_n(rst_n), .inc(inc), .cnt_wr(cnt_wr),
    .cnt_wdata(cnt_wdata), .ovf_clr(ovf_clr), .cnt_q(cnt_rdata),
    .ovf_q(ovf_flag)
  );

  evtc_irq_router #(.NUM_CORES(NUM_CORES)) u_irq (
    .clk(clk), .rst_n(rst_n), .ovf(ovf_flag), .irq_on(fields.irq_on),
    .core_en(core_irq_en), .core_irq(core_irq)
  );

  assign ctl_rdata = ctl_q;

  // R2: control word loads unchanged
  a_r2_ctl_load: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_wr |=> (ctl_rdata == $past(ctl_wdata)));
  // R3: disabled and not written, the counter holds
  a_r3_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (!(ctl_rdata[LEN_BIT] && glb_en) && !cnt_wr) |=> $stable(cnt_rdata));
endmodule

// File: tb/evt_thresh_counter_tb_top.sv
module evt_thresh_counter_tb_top;
  localparam int NC = 4;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  evt_count;
  logic        glb_en;
  logic [NC-1:0] core_irq_en;
  logic        ctl_wr;
  logic [31:0] ctl_wdata;
  logic [31:0] ctl_rdata;
  logic        cnt_wr;
  logic [47:0] cnt_wdata;
  logic [47:0] cnt_rdata;
  logic        ovf_clr;
  logic        ovf_flag;
  logic [NC-1:0] core_irq;

  always #2.5 clk = ~clk;

  evt_thresh_counter dut_i (
    .clk(clk), .rst_n(rst_n), .evt_count(evt_count), .glb_en(glb_en),
    .core_irq_en(core_irq_en), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
    .ctl_rdata(ctl_rdata), .cnt_wr(cnt_wr), .cnt_wdata(cnt_wdata),
    .cnt_rdata(cnt_rdata), .ovf_clr(ovf_clr), .ovf_flag(ovf_flag),
    .core_irq(core_irq)
  );

  int    n_vec = 0;
  int    n_bad = 0;
  string req   = "R1";

  logic [31:0] m_ctl;
  logic [47:0] m_cnt;
  logic        m_ovf;
  logic        m_prev;

  function automatic logic [NC-1:0] m_irq();
    return (m_ovf && m_ctl[20]) ? core_irq_en : '0;
  endfunction

  task automatic compare();
    n_vec++;
    if (ctl_rdata !== m_ctl || cnt_rdata !== m_cnt || ovf_flag !== m_ovf
        || core_irq !== m_irq()) begin
      n_bad++;
      $display("FAIL %s: ctl=%h cnt=%h ovf=%b irq=%b expected ctl=%h cnt=%h ovf=%b irq=%b",
               req, ctl_rdata, cnt_rdata, ovf_flag, core_irq,
               m_ctl, m_cnt, m_ovf, m_irq());
    end
  endtask

  // one clock: inputs already driven; update model at posedge, compare at negedge
  task automatic step();
    logic [7:0]  thr;
    logic        act, cond, carry;
    logic [48:0] sum;
    logic [47:0] inc;
    @(posedge clk);
    thr  = m_ctl[31:24];
    act  = m_ctl[22] && glb_en;
    if (thr == 0)      cond = (evt_count != 0);
    else if (m_ctl[23]) cond = (evt_count < thr);
    else               cond = (evt_count >= thr);
    inc = 0;
    if (act) begin
      if (m_ctl[18])     inc = 48'(cond && !m_prev);
      else if (thr == 0) inc = 48'(evt_count);
      else               inc = 48'(cond);
    end
    m_prev = cond;
    sum   = {1'b0, m_cnt} + {1'b0, inc};
    carry = sum[48] && !cnt_wr;
    m_cnt = cnt_wr ? cnt_wdata : sum[47:0];
    m_ovf = carry || (m_ovf && !ovf_clr);
    if (ctl_wr) m_ctl = ctl_wdata;
    @(negedge clk);
    compare();
  endtask

  task automatic idle_inputs();
    ctl_wr = 0; cnt_wr = 0; ovf_clr = 0;
  endtask

  task automatic wr_ctl(input logic [31:0] v);
    ctl_wr = 1; ctl_wdata = v; step(); ctl_wr = 0;
  endtask

  task automatic wr_cnt(input logic [47:0] v);
    cnt_wr = 1; cnt_wdata = v; step(); cnt_wr = 0;
  endtask

  task automatic run_rand(input int n, input int maxv);
    for (int i = 0; i < n; i++) begin
      evt_count = 8'($urandom_range(0, maxv));
      step();
    end
  endtask

  initial begin
    #200000;
    n_bad++;
    $display("FAIL watchdog: run hung, actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    rst_n = 0; evt_count = 0; glb_en = 0; core_irq_en = '0;
    ctl_wdata = 0; cnt_wdata = 0; idle_inputs();
    m_ctl = 0; m_cnt = 0; m_ovf = 0; m_prev = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1: reset state
    req = "R1"; compare(); step(); step();

    // R2: register loads
    req = "R2"; wr_ctl(32'h00A5_0F0F); step(); wr_cnt(48'h1234_5678_9ABC); step();

    // R3: local enable / global enable combinations
    req = "R3";
    wr_ctl(32'h0200_0000); glb_en = 1; run_rand(10, 5);
    wr_ctl(32'h0240_0000); glb_en = 0; run_rand(10, 5);
    glb_en = 1; run_rand(10, 5);

    // R4: threshold, greater-or-equal
    req = "R4"; wr_ctl(32'h0340_0000); run_rand(40, 6);
    evt_count = 3; step(); evt_count = 2; step(); evt_count = 255; step();

    // R5: threshold, less-than
    req = "R5"; wr_ctl(32'h03C0_0000); run_rand(40, 6);
    evt_count = 3; step(); evt_count = 2; step(); evt_count = 0; step();

    // R6: zero threshold adds raw count, invert ignored
    req = "R6"; wr_ctl(32'h0040_0000); run_rand(30, 255);
    wr_ctl(32'h0080_0000 | 32'h0040_0000); run_rand(30, 255);

    // R7: edge mode, thresholded and raw
    req = "R7"; wr_ctl(32'h0444_0000); run_rand(60, 8);
    for (int i = 0; i < 6; i++) begin
      evt_count = 8'(i % 2 ? 9 : 1); step();
    end
    wr_ctl(32'h0044_0000); run_rand(40, 2);

    // R8: wrap and sticky overflow
    req = "R8"; core_irq_en = 4'b1010;
    wr_ctl(32'h0050_0000); wr_cnt(48'hFFFF_FFFF_FFF0);
    run_rand(10, 40); step();
    ovf_clr = 1; step(); ovf_clr = 0; step();
    wr_cnt(48'hFFFF_FFFF_FFFE); evt_count = 5; ovf_clr = 1; step(); ovf_clr = 0;
    evt_count = 0; step();
    wr_ctl(32'h0354_0000); wr_cnt(48'hFFFF_FFFF_FFFF); run_rand(20, 8);

    // R9: routing mask
    req = "R9";
    for (int m = 0; m < 16; m++) begin
      core_irq_en = 4'(m); step();
    end
    wr_ctl(32'h0344_0000); core_irq_en = 4'hF; step();
    wr_ctl(32'h0354_0000); step();

    // R10: write collides with an overflowing increment
    req = "R10"; ovf_clr = 1; step(); ovf_clr = 0;
    wr_ctl(32'h0050_0000); wr_cnt(48'hFFFF_FFFF_FFFF);
    evt_count = 200; wr_cnt(48'h0000_0000_0007); step();
    evt_count = 1; wr_cnt(48'h0000_0000_0100); step();

    // mixed traffic
    req = "R3";
    for (int k = 0; k < 200; k++) begin
      glb_en = 1'($urandom_range(0, 1));
      if ($urandom_range(0, 15) == 0) begin
        ctl_wr = 1;
        ctl_wdata = {8'($urandom_range(0, 4)), 8'($urandom() & 8'hFD),
                     16'($urandom())};
      end
      if ($urandom_range(0, 31) == 0) begin
        cnt_wr = 1; cnt_wdata = 48'hFFFF_FFFF_FF00 | 48'($urandom_range(0, 255));
      end
      ovf_clr = ($urandom_range(0, 20) == 0);
      evt_count = 8'($urandom_range(0, 10));
      step(); idle_inputs();
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule